// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses for one read or write burst of a double-data-rate memory. A burst is requested with a one-cycle `start` pulse. The pulse carries a start column, a burst length code, a wrap order and a device organisation, all taken from the controller's mode settings. Two data beats move in each clock, so the block presents two column addresses per cycle: the even beat on `col_even` and the odd beat on `col_odd`. It flags the cycle that carries the final pair.

Every beat stays inside the aligned block of burst-length columns that contains the start column. The sequential order counts upward through the low bits and wraps around. The interleaved order XORs the low bits of the start column with the beat index. The organisation input sets how many column bits are valid. Bits above that width are forced to zero, both in the latched start column and in every address the block emits.

The sequencer has three states. `ST_IDLE` waits for a burst. `ST_BURST` walks through the beat pairs. `ST_FAULT` holds a configuration error. The transitions are:
- IDLE→BURST on an accepted start with a valid configuration.
- IDLE→FAULT on an accepted start with an invalid configuration.
- BURST→BURST on a valid start during the last pair; this chains into a new burst.
- BURST→FAULT on an invalid start during the last pair.
- BURST→IDLE after the last pair when no start is present.
- FAULT→BURST and FAULT→FAULT on the next start, depending on whether its configuration is valid.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `beat_valid`, `burst_last` and `cfg_err` are all 0.
- R2: Burst length codes are 2'b01 for 2 beats, 2'b10 for 4 beats and 2'b11 for 8 beats. An accepted burst shows its first pair in the cycle after the `start` edge, keeps `beat_valid` high for exactly BL/2 cycles, and then drops it.
- R3: With `ilv_mode`=0 (sequential), beat i has low log2(BL) bits equal to (start low bits + i) mod BL.
- R4: With `ilv_mode`=1 (interleaved), beat i has low log2(BL) bits equal to start low bits XOR i.
- R5: Column bits at and above log2(BL) equal those of the start column on every beat of the burst.
- R6: Organisation code 2'b00 gives 11 valid column bits, 2'b01 gives 10 and 2'b10 gives 9. Bits above the valid width are 0 on both address outputs.
- R7: `burst_last` is 1 exactly in the cycle carrying the final beat pair, and only while `beat_valid` is 1.
- R8: A start with burst length code 2'b00 or organisation code 2'b11 produces no beats. It raises `cfg_err` from the next cycle, and `cfg_err` stays high until a start with a valid configuration is accepted.
- R9: A `start` during a burst, except in its last pair, is ignored, and the running burst continues unchanged.
- R10: A `start` in the cycle of the last pair is accepted, and the new burst's first pair follows in the next cycle with no gap.
- R11: In each cycle, `col_even` carries beat 2k and `col_odd` carries beat 2k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request pulse |
| start_col | input | 11 | Starting column of the burst |
| bl_code | input | 2 | Burst length code (01=2, 10=4, 11=8, 00 invalid) |
| ilv_mode | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| org | input | 2 | Organisation: 00 x4, 01 x8, 10 x16, 11 invalid |
| beat_valid | output | 1 | Address pair valid this cycle |
| col_even | output | 11 | Column of the even beat of this pair |
| col_odd | output | 11 | Column of the odd beat of this pair |
| burst_last | output | 1 | This pair is the final one of the burst |
| cfg_err | output | 1 | Last accepted start had an invalid configuration |

## Verification
The sweep covers every low four-bit start offset under two different upper-bit patterns, for each burst length, each wrap order and each organisation. Because the offsets exceed the burst length, the sweep separates correct wrapping from carry into the fixed upper bits. The two wrap orders agree only on some beats, so the sweep also tells them apart. Upper patterns with all high bits set expose any failure to clear bits above the organisation's width. Directed sequences then cover a start ignored mid-burst, a start chained on the last pair, and the entry into and exit from the error state.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_FAULT = 2'd2
    } seq_state_t;

    localparam logic [1:0] BLC_NONE = 2'b00;
    localparam logic [1:0] ORG_BAD  = 2'b11;

    localparam int BEATS_PER_CLK = 2;
    localparam int MAX_LG_BL     = 3;

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic [1:0]       bl_code,
    input  logic [1:0]       org,
    output logic             cfg_ok,
    output logic [1:0]       lg_bl,
    output logic [COL_W-1:0] width_mask
);
    localparam logic [COL_W-1:0] ALL_ONES = '1;

    always_comb begin
        cfg_ok = (bl_code != BLC_NONE) && (org != ORG_BAD);
        lg_bl  = bl_code;
        unique case (org)
            2'b00:   width_mask = ALL_ONES;
            2'b01:   width_mask = ALL_ONES >> 1;
            2'b10:   width_mask = ALL_ONES >> 2;
            default: width_mask = '0;
        endcase
    end

endmodule

// File: rtl/burst_lane_addr.sv
module burst_lane_addr #(
    parameter int COL_W = 11,
    parameter int LANE  = 0
) (
    input  logic [COL_W-1:0] base,
    input  logic [1:0]       pair_idx,
    input  logic [1:0]       lg_bl,
    input  logic             ilv,
    input  logic [COL_W-1:0] width_mask,
    output logic [COL_W-1:0] addr
);
    logic [2:0]       beat;
    logic [COL_W-1:0] low_mask;
    logic [COL_W-1:0] beat_ext;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    always_comb begin
        beat     = {pair_idx, 1'(LANE)};
        beat_ext = COL_W'(beat);
        low_mask = (COL_W'(1) << lg_bl) - COL_W'(1);
        seq_low  = (base + beat_ext) & low_mask;
        ilv_low  = (base ^ beat_ext) & low_mask;
        addr     = ((base & ~low_mask) | (ilv ? ilv_low : seq_low)) & width_mask;
    end

endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_col_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cfg_ok,
    input  logic [1:0] lg_bl_q,
    output logic       accept,
    output logic [1:0] pair_idx,
    output logic       in_burst,
    output logic       last_pair,
    output logic       in_fault
);
    seq_state_t state_q, state_d;
    logic [1:0] pair_q, pair_d;
    logic [1:0] pair_max;

    always_comb begin
        unique case (lg_bl_q)
            2'd2:    pair_max = 2'd1;
            2'd3:    pair_max = 2'd3;
            default: pair_max = 2'd0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        pair_d  = pair_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FAULT: begin
                if (start) begin
                    accept  = 1'b1;
                    pair_d  = 2'd0;
                    state_d = cfg_ok ? ST_BURST : ST_FAULT;
                end
            end
            ST_BURST: begin
                if (pair_q == pair_max) begin
                    if (start) begin
                        accept  = 1'b1;
                        pair_d  = 2'd0;
                        state_d = cfg_ok ? ST_BURST : ST_FAULT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    pair_d = pair_q + 2'd1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                pair_d  = 2'd0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pair_q  <= 2'd0;
        end else begin
            state_q <= state_d;
            pair_q  <= pair_d;
        end
    end

    always_comb begin
        pair_idx  = pair_q;
        in_burst  = (state_q == ST_BURST);
        in_fault  = (state_q == ST_FAULT);
        last_pair = in_burst && (pair_q == pair_max);
    end

    // R8
    fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cfg_ok) |=> (state_q == ST_FAULT));

    // R9
    ignore_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && !last_pair) |=> (state_q == ST_BURST && pair_q == $past(pair_q) + 2'd1));

    // R2
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_pair && !start) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       bl_code,
    input  logic             ilv_mode,
    input  logic [1:0]       org,
    output logic             beat_valid,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd,
    output logic             burst_last,
    output logic             cfg_err
);
    localparam int LANES = BEATS_PER_CLK;

    logic             cfg_ok;
    logic [1:0]       lg_bl_d;
    logic [COL_W-1:0] wmask_d;
    logic             accept;
    logic [1:0]       pair_idx;
    logic             in_burst;
    logic             last_pair;
    logic             in_fault;

    logic [COL_W-1:0] base_q;
    logic [1:0]       lg_bl_q;
    logic             ilv_q;
    logic [COL_W-1:0] wmask_q;
    logic [COL_W-1:0] lane_addr [LANES];

    burst_cfg_decode #(.COL_W(COL_W)) cfg_i (
        .bl_code    (bl_code),
        .org        (org),
        .cfg_ok     (cfg_ok),
        .lg_bl      (lg_bl_d),
        .width_mask (wmask_d)
    );

    burst_seq_fsm seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_ok    (cfg_ok),
        .lg_bl_q   (lg_bl_q),
        .accept    (accept),
        .pair_idx  (pair_idx),
        .in_burst  (in_burst),
        .last_pair (last_pair),
        .in_fault  (in_fault)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            lg_bl_q <= 2'd1;
            ilv_q   <= 1'b0;
            wmask_q <= '0;
        end else if (accept && cfg_ok) begin
            base_q  <= start_col & wmask_d;
            lg_bl_q <= lg_bl_d;
            ilv_q   <= ilv_mode;
            wmask_q <= wmask_d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        burst_lane_addr #(.COL_W(COL_W), .LANE(g)) lane_i (
            .base       (base_q),
            .pair_idx   (pair_idx),
            .lg_bl      (lg_bl_q),
            .ilv        (ilv_q),
            .width_mask (wmask_q),
            .addr       (lane_addr[g])
        );
    end

    always_comb begin
        beat_valid = in_burst;
        burst_last = last_pair;
        cfg_err    = in_fault;
        col_even   = in_burst ? lane_addr[0] : '0;
        col_odd    = in_burst ? lane_addr[1] : '0;
    end

    // R7
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_last |-> beat_valid);

    // R8
    err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !beat_valid);

    // R6
    width_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (((col_even | col_odd) & ~wmask_q) == '0));

    // R5
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !burst_last) |=> ((col_even >> MAX_LG_BL) == $past(col_even >> MAX_LG_BL)));

    // R11
    lanes_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (col_even != col_odd));

endmodule

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] start_col = '0;
    logic [1:0]  bl_code = 2'b01;
    logic        ilv_mode = 1'b0;
    logic [1:0]  org = 2'b00;
    logic        beat_valid;
    logic [10:0] col_even;
    logic [10:0] col_odd;
    logic        burst_last;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(11)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .bl_code(bl_code), .ilv_mode(ilv_mode), .org(org),
        .beat_valid(beat_valid), .col_even(col_even), .col_odd(col_odd),
        .burst_last(burst_last), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_col(input int sm, input int bl, input int ty, input int i);
        int low = sm % bl;
        int up  = sm - low;
        return up + (ty != 0 ? (low ^ i) : ((low + i) % bl));
    endfunction

    task automatic drive(input int s, input int blc, input int ty, input int og);
        start     = 1'b1;
        start_col = 11'(s);
        bl_code   = 2'(blc);
        ilv_mode  = ty[0];
        org       = 2'(og);
    endtask

    task automatic run_burst(input int s, input int blc, input int ty, input int og);
        int bl = 1 << blc;
        int wm = (1 << (11 - og)) - 1;
        int sm = s & wm;
        @(negedge clk);
        drive(s, blc, ty, og);
        @(negedge clk);
        start = 1'b0;
        for (int p = 0; p < bl / 2; p++) begin
            check("R2 valid", int'(beat_valid), 1);
            check(ty != 0 ? "R4 interleaved even" : "R3 sequential even",
                  int'(col_even), exp_col(sm, bl, ty, 2 * p));
            check("R11 odd beat", int'(col_odd), exp_col(sm, bl, ty, 2 * p + 1));
            check("R5 upper bits", int'(col_even) & ~(bl - 1), sm & ~(bl - 1));
            check("R6 width", (int'(col_even) | int'(col_odd)) & ~wm, 0);
            check("R7 last", int'(burst_last), (p == bl / 2 - 1) ? 1 : 0);
            @(negedge clk);
        end
        check("R2 end", int'(beat_valid), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", int'(beat_valid), 0);
        check("R1 last", int'(burst_last), 0);
        check("R1 err", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after", int'(beat_valid), 0);

        for (int og = 0; og < 3; og++)
            for (int blc = 1; blc < 4; blc++)
                for (int ty = 0; ty < 2; ty++)
                    for (int u = 0; u < 2; u++)
                        for (int lo = 0; lo < 16; lo++)
                            run_burst((u != 0 ? 11'h7F0 : 11'h2A0) | lo, blc, ty, og);

        // R9: start mid-burst is ignored
        @(negedge clk);
        drive(2, 3, 0, 0);
        @(negedge clk);
        check("R9 pair0", int'(col_even), 2);
        drive(0, 1, 1, 2);
        @(negedge clk);
        start = 1'b0;
        check("R9 pair1 even", int'(col_even), 4);
        check("R9 pair1 odd", int'(col_odd), 5);
        @(negedge clk);
        check("R9 pair2 even", int'(col_even), 6);
        check("R9 pair2 last", int'(burst_last), 0);
        @(negedge clk);
        check("R9 pair3 odd", int'(col_odd), 1);
        check("R9 pair3 last", int'(burst_last), 1);
        @(negedge clk);
        check("R9 idle", int'(beat_valid), 0);

        // R10: chained start on last pair
        drive(5, 2, 0, 0);
        @(negedge clk);
        start = 1'b0;
        check("R10 first even", int'(col_even), 5);
        @(negedge clk);
        check("R10 last", int'(burst_last), 1);
        drive(3, 1, 1, 0);
        @(negedge clk);
        start = 1'b0;
        check("R10 no gap", int'(beat_valid), 1);
        check("R10 even", int'(col_even), 3);
        check("R10 odd", int'(col_odd), 2);
        @(negedge clk);
        check("R10 end", int'(beat_valid), 0);

        // R8: bad burst length, bad organisation, recovery
        drive(1, 0, 0, 0);
        @(negedge clk);
        start = 1'b0;
        check("R8 no beat", int'(beat_valid), 0);
        check("R8 err set", int'(cfg_err), 1);
        repeat (2) @(negedge clk);
        check("R8 err held", int'(cfg_err), 1);
        drive(1, 2, 0, 3);
        @(negedge clk);
        start = 1'b0;
        check("R8 bad org err", int'(cfg_err), 1);
        check("R8 bad org no beat", int'(beat_valid), 0);
        drive(6, 1, 0, 1);
        @(negedge clk);
        start = 1'b0;
        check("R8 err cleared", int'(cfg_err), 0);
        check("R8 recovered", int'(col_even), 6);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule